// File: doc/BRIEF.md
# LIN Transmit Bit Error Monitor

This block sits beside a single-wire LIN transmitter. The transmitter supplies the bit it wants on the bus and a 16x oversampling tick, and the block reads the bus level back on each tick. It compares the read-back level with the driven level at one chosen sample of the bit. A mismatch sets a sticky bit error flag. A separate sticky flag records a physical bus fault, which is a bus held low for a whole bit while the block drives it high.

A small state machine owns the bus. It has three states. `ST_IDLE` means nothing is driven. `ST_DRIVE` means a bit is on the bus and its samples are being counted. `ST_HALT` means the bus has been released after an error. The transitions are:

- `IDLE->DRIVE`: a byte start is accepted.
- `DRIVE->DRIVE`: a further bit start arrives.
- `DRIVE->IDLE`: sample 16 passes with no new bit.
- `DRIVE->HALT`: a bit error occurs while stop-on-error is enabled.
- `HALT->IDLE`: software clears the bit error flag.

Other outputs depend on the flags:

- Transmit DMA requests are masked while an error is pending.
- The error interrupt is gated by an enable bit.
- The receive pin may be inverted before it is used.

Top module: `lin_bit_error_monitor`

## Requirements
- R1: Out of reset both flags are 0, `err_irq` is 0, `txd` is 1 and `txd_oe` is 0.
- R2: In standard detection the block counts a bit's ticks 1 to 16 from its `bit_start` tick. It compares the read-back level with the driven bit at tick 16. A mismatch there sets `bit_err` one clock after that tick, and mismatches at other ticks are ignored.
- R3: When `lin_mode` and `fast_en` are both 1, the comparison moves to tick 9 if `fast_late` is 0, or to tick 13 if `fast_late` is 1. Mismatches at all other ticks are ignored.
- R4: `bit_err` and `phy_err` stay set until a one-cycle strobe on `berr_clr` or `pberr_clr` clears them. When a set and a clear of the same flag occur together, the flag is set.
- R5: When `lin_mode` and `stop_on_err` are both 1, a bit error releases the bus in the same clock in which `bit_err` rises: `txd`=1 and `txd_oe`=0. The bus stays released until `bit_err` is cleared.
- R6: While `byte_hold` is 1, a `byte_start` is ignored and no transmission begins. `byte_hold` is 1 when `lin_mode`, `stop_on_err` and `bit_err` are all 1.
- R7: `dma_req` follows `dma_req_in`. It is forced to 0 when `lin_mode` and `dma_stop_on_err` are both 1 and either flag is set.
- R8: `err_irq` is 1 exactly when `bit_err` and `err_irq_en` are both 1.
- R9: `rx_data` equals `rxd` XOR `rx_invert`, and this level is the one used in every comparison.
- R10: `txd_oe` is 1 only while a bit is being driven and `tx_out_en` is 1.
- R11: `phy_err` is set at tick 16 of a driven 1 bit if the read-back level was 0 at all 16 ticks.
- R12: When `lin_mode` is 0, `fast_en`, `stop_on_err` and `dma_stop_on_err` have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| os_tick | input | 1 | Oversampling tick, 16 per bit |
| bit_start | input | 1 | With a tick: this tick is sample 1 of a new bit |
| byte_start | input | 1 | With bit_start: the new bit begins a byte |
| tx_bit | input | 1 | Level to drive for the starting bit |
| rxd | input | 1 | Raw read-back pin |
| lin_mode | input | 1 | Enables the LIN-only controls |
| fast_en | input | 1 | Selects fast (early) detection |
| fast_late | input | 1 | Fast sample point: 0 means tick 9, 1 means tick 13 |
| stop_on_err | input | 1 | Release the bus and hold bytes on bit error |
| dma_stop_on_err | input | 1 | Mask DMA requests while a flag is set |
| err_irq_en | input | 1 | Bit error interrupt enable |
| rx_invert | input | 1 | Invert the read-back pin |
| tx_out_en | input | 1 | Allows the output enable to be driven |
| dma_req_in | input | 1 | Raw transmit DMA request |
| berr_clr | input | 1 | Clear strobe for bit_err |
| pberr_clr | input | 1 | Clear strobe for phy_err |
| txd | output | 1 | Bus drive level, 1 when released |
| txd_oe | output | 1 | Bus output enable |
| rx_data | output | 1 | Polarity-corrected receive level |
| bit_err | output | 1 | Sticky bit error flag |
| phy_err | output | 1 | Sticky physical bus error flag |
| err_irq | output | 1 | Bit error interrupt request |
| dma_req | output | 1 | Gated transmit DMA request |
| byte_hold | output | 1 | New bytes are being refused |

## Verification
The bench builds the block with its defaults: 16 ticks per bit and fast sample points 9 and 13. Each sample point can therefore be hit by a single-tick glitch on the read-back line, and a neighbouring tick can be glitched to show it is ignored. The tick is issued every other clock, so the one-clock delay from the deciding tick to the flag is visible separately from the tick spacing. A behavioural model is compared against every output on every clock. It covers the halt, the refused byte start, clear-versus-set collisions and the case with LIN mode off.

// File: rtl/lin_bem_pkg.sv
package lin_bem_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_DRIVE = 2'd1,
        ST_HALT  = 2'd2
    } bem_state_t;
endpackage

// File: rtl/lin_bem_sampler.sv
// Tracks the sample index within the current bit, the latched drive level
// and whether a high level was seen at any sample so far.
module lin_bem_sampler #(
    parameter int unsigned OSR = 16,
    localparam int unsigned IW = $clog2(OSR + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic          step,
    input  logic          tx_bit,
    input  logic          rx_lvl,
    output logic [IW-1:0] idx,
    output logic          drv_bit,
    output logic          seen_hi
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idx     <= '0;
            drv_bit <= 1'b1;
            seen_hi <= 1'b0;
        end else if (load) begin
            idx     <= IW'(1);
            drv_bit <= tx_bit;
            seen_hi <= rx_lvl;
        end else if (step) begin
            idx     <= idx + 1'b1;
            seen_hi <= seen_hi | rx_lvl;
        end
    end
endmodule

// File: rtl/lin_bem_flag.sv
// Sticky flag with clear strobe; a set in the same cycle wins.
module lin_bem_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic set,
    input  logic clr,
    output logic q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   q <= 1'b0;
        else if (set) q <= 1'b1;
        else if (clr) q <= 1'b0;
    end
endmodule

// File: rtl/lin_bit_error_monitor.sv
module lin_bit_error_monitor
    import lin_bem_pkg::*;
#(
    parameter int unsigned OSR        = 16,
    parameter int unsigned FAST_EARLY = 9,
    parameter int unsigned FAST_LATE  = 13
) (
    input  logic clk,
    input  logic rst_n,
    input  logic os_tick,
    input  logic bit_start,
    input  logic byte_start,
    input  logic tx_bit,
    input  logic rxd,
    input  logic lin_mode,
    input  logic fast_en,
    input  logic fast_late,
    input  logic stop_on_err,
    input  logic dma_stop_on_err,
    input  logic err_irq_en,
    input  logic rx_invert,
    input  logic tx_out_en,
    input  logic dma_req_in,
    input  logic berr_clr,
    input  logic pberr_clr,
    output logic txd,
    output logic txd_oe,
    output logic rx_data,
    output logic bit_err,
    output logic phy_err,
    output logic err_irq,
    output logic dma_req,
    output logic byte_hold
);
    localparam int unsigned IW = $clog2(OSR + 1);

    bem_state_t    state, state_nx;
    logic [IW-1:0] idx, idx_inc, target;
    logic          drv_bit, seen_hi, rx_lvl;
    logic          fast_on, halt_on, dstop_on;
    logic          accept, step, cmp_fire, berr_set, pberr_set, halt_evt;
    logic          is_drive;

    assign rx_lvl   = rxd ^ rx_invert;
    assign fast_on  = lin_mode & fast_en;
    assign halt_on  = lin_mode & stop_on_err;
    assign dstop_on = lin_mode & dma_stop_on_err;
    assign is_drive = (state == ST_DRIVE);
    assign idx_inc  = idx + 1'b1;
    assign target   = fast_on ? (fast_late ? IW'(FAST_LATE) : IW'(FAST_EARLY))
                              : IW'(OSR);

    assign accept    = os_tick & bit_start & (state != ST_HALT)
                     & (is_drive | byte_start)
                     & ~(byte_start & halt_on & bit_err);
    assign step      = os_tick & is_drive & ~accept & (idx != IW'(OSR));
    assign cmp_fire  = step & (idx_inc == target);
    assign berr_set  = cmp_fire & (rx_lvl != drv_bit);
    assign pberr_set = step & (idx_inc == IW'(OSR)) & drv_bit & ~seen_hi & ~rx_lvl;
    assign halt_evt  = berr_set & halt_on;

    lin_bem_sampler #(.OSR(OSR)) u_samp (
        .clk(clk), .rst_n(rst_n), .load(accept), .step(step),
        .tx_bit(tx_bit), .rx_lvl(rx_lvl),
        .idx(idx), .drv_bit(drv_bit), .seen_hi(seen_hi)
    );

    lin_bem_flag u_berr (
        .clk(clk), .rst_n(rst_n), .set(berr_set), .clr(berr_clr), .q(bit_err)
    );

    lin_bem_flag u_pberr (
        .clk(clk), .rst_n(rst_n), .set(pberr_set), .clr(pberr_clr), .q(phy_err)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: begin
                if (accept) state_nx = ST_DRIVE;
            end
            ST_DRIVE: begin
                if (halt_evt)
                    state_nx = ST_HALT;
                else if (os_tick && !accept && idx == IW'(OSR))
                    state_nx = ST_IDLE;
            end
            ST_HALT: begin
                if (!bit_err) state_nx = ST_IDLE;
            end
            default: state_nx = ST_IDLE;
        endcase
    end

    always_comb begin
        txd       = is_drive ? drv_bit : 1'b1;
        txd_oe    = is_drive & tx_out_en;
        rx_data   = rx_lvl;
        err_irq   = bit_err & err_irq_en;
        dma_req   = dma_req_in & ~(dstop_on & (bit_err | phy_err));
        byte_hold = halt_on & bit_err;
    end
endmodule

// File: rtl/lin_bem_checker.sv
module lin_bem_checker (
    input logic clk,
    input logic rst_n,
    input logic bit_err,
    input logic phy_err,
    input logic berr_clr,
    input logic pberr_clr,
    input logic txd,
    input logic txd_oe,
    input logic tx_out_en,
    input logic err_irq,
    input logic dma_req,
    input logic dstop_on,
    input logic halt_on,
    input logic byte_hold,
    input logic is_drive
);
    // R4: a flag holds without a clear
    a_r4_berr_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        $past(bit_err) && !$past(berr_clr) |-> bit_err);
    a_r4_pberr_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        $past(phy_err) && !$past(pberr_clr) |-> phy_err);
    // R4: a flag only falls after a clear
    a_r4_berr_fall: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(bit_err) |-> $past(berr_clr));
    // R5: bus released when the error appears
    a_r5_release: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bit_err) && $past(halt_on) |-> (txd && !txd_oe));
    // R6: no transmission starts while held
    a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !is_drive && byte_hold |=> !is_drive);
    // R7: masked DMA
    a_r7_dma_mask: assert property (@(posedge clk) disable iff (!rst_n)
        dstop_on && (bit_err || phy_err) |-> !dma_req);
    // R8: interrupt needs the flag
    a_r8_irq: assert property (@(posedge clk) disable iff (!rst_n)
        err_irq |-> bit_err);
    // R10: output enable needs the direction bit
    a_r10_oe: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_out_en |-> !txd_oe);
endmodule

bind lin_bit_error_monitor lin_bem_checker u_chk (
    .clk(clk), .rst_n(rst_n), .bit_err(bit_err), .phy_err(phy_err),
    .berr_clr(berr_clr), .pberr_clr(pberr_clr), .txd(txd), .txd_oe(txd_oe),
    .tx_out_en(tx_out_en), .err_irq(err_irq), .dma_req(dma_req),
    .dstop_on(dstop_on), .halt_on(halt_on), .byte_hold(byte_hold),
    .is_drive(is_drive)
);

// File: tb/sim_lin_bit_error_monitor.sv
`timescale 1ns/1ps
module sim_lin_bit_error_monitor;
    localparam int CLK_PERIOD = 10;

    logic clk = 1'b0, rst_n = 1'b0;
    logic os_tick = 0, bit_start = 0, byte_start = 0, tx_bit = 1, rxd = 1;
    logic lin_mode = 0, fast_en = 0, fast_late = 0, stop_on_err = 0;
    logic dma_stop_on_err = 0, err_irq_en = 0, rx_invert = 0, tx_out_en = 1;
    logic dma_req_in = 0, berr_clr = 0, pberr_clr = 0;
    logic txd, txd_oe, rx_data, bit_err, phy_err, err_irq, dma_req, byte_hold;

    int n_chk = 0, n_bad = 0, cycles = 0;
    bit running = 0, done = 0;

    // reference model state
    int m_st = 0, m_idx = 0, m_bit = 1, m_hi = 0, m_berr = 0, m_pberr = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    lin_bit_error_monitor u0 (
        .clk(clk), .rst_n(rst_n), .os_tick(os_tick), .bit_start(bit_start),
        .byte_start(byte_start), .tx_bit(tx_bit), .rxd(rxd), .lin_mode(lin_mode),
        .fast_en(fast_en), .fast_late(fast_late), .stop_on_err(stop_on_err),
        .dma_stop_on_err(dma_stop_on_err), .err_irq_en(err_irq_en),
        .rx_invert(rx_invert), .tx_out_en(tx_out_en), .dma_req_in(dma_req_in),
        .berr_clr(berr_clr), .pberr_clr(pberr_clr), .txd(txd), .txd_oe(txd_oe),
        .rx_data(rx_data), .bit_err(bit_err), .phy_err(phy_err),
        .err_irq(err_irq), .dma_req(dma_req), .byte_hold(byte_hold)
    );

    task automatic chk(string tag, logic act, logic exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %b expected %b at %0t", tag, act, exp, $time);
        end
    endtask

    // behavioural model, advanced on each rising edge
    always @(posedge clk) begin
        int rx, stp, tgt, bset, pset, ok;
        cycles++;
        if (!rst_n) begin
            m_st = 0; m_idx = 0; m_bit = 1; m_hi = 0; m_berr = 0; m_pberr = 0;
        end else begin
            rx   = rxd ^ rx_invert;
            stp  = lin_mode && stop_on_err;
            tgt  = (lin_mode && fast_en) ? (fast_late ? 13 : 9) : 16;
            bset = 0; pset = 0;
            if (m_st == 2) begin
                if (!m_berr) m_st = 0;
            end else if (os_tick) begin
                ok = bit_start && (m_st == 1 || byte_start) && !(byte_start && stp && m_berr);
                if (ok) begin
                    m_st = 1; m_idx = 1; m_bit = tx_bit; m_hi = rx;
                end else if (m_st == 1) begin
                    if (m_idx == 16) m_st = 0;
                    else begin
                        m_idx++;
                        m_hi = m_hi | rx;
                        if (m_idx == tgt && rx != m_bit) bset = 1;
                        if (m_idx == 16 && m_bit == 1 && m_hi == 0) pset = 1;
                        if (bset && stp) m_st = 2;
                    end
                end
            end
            m_berr  = bset ? 1 : (berr_clr ? 0 : m_berr);
            m_pberr = pset ? 1 : (pberr_clr ? 0 : m_pberr);
        end
    end

    // compare every output on every falling edge
    always @(negedge clk) begin
        if (running) begin
            chk("R5 R10 txd", txd, (m_st == 1) ? m_bit[0] : 1'b1);
            chk("R5 R10 txd_oe", txd_oe, (m_st == 1) && tx_out_en);
            chk("R2 R3 R4 R12 bit_err", bit_err, m_berr != 0);
            chk("R4 R11 phy_err", phy_err, m_pberr != 0);
            chk("R8 err_irq", err_irq, (m_berr != 0) && err_irq_en);
            chk("R7 R12 dma_req", dma_req,
                dma_req_in && !(lin_mode && dma_stop_on_err && (m_berr != 0 || m_pberr != 0)));
            chk("R9 rx_data", rx_data, rxd ^ rx_invert);
            chk("R6 byte_hold", byte_hold, lin_mode && stop_on_err && (m_berr != 0));
        end
    end

    always @(posedge clk) begin
        if (cycles > 100000 && !done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    task automatic step(logic tk, logic bs, logic by, logic b, logic lvl);
        @(posedge clk); #1;
        os_tick = tk; bit_start = bs; byte_start = by; tx_bit = b;
        rxd = lvl ^ rx_invert;
    endtask

    // mode 0 echo, 1 glitch at sample gs, 2 read back stuck at 0
    task automatic send_bit(logic first, logic b, int mode, int gs);
        for (int s = 1; s <= 16; s++) begin
            logic lvl;
            lvl = (mode == 2) ? 1'b0 : ((mode == 1 && s == gs) ? ~b : b);
            step(1, s == 1, first && s == 1, b, lvl);
            step(0, 0, 0, b, lvl);
        end
    endtask

    task automatic send_byte(logic [7:0] v, int mode, int gs, int gbit);
        for (int i = 0; i < 10; i++) begin
            logic b;
            b = (i == 0) ? 1'b0 : ((i == 9) ? 1'b1 : v[i-1]);
            send_bit(i == 0, b, (i == gbit) ? mode : 0, gs);
        end
        step(0, 0, 0, 1, 1);
        step(0, 0, 0, 1, 1);
    endtask

    task automatic clear_flags();
        @(posedge clk); #1; berr_clr = 1; pberr_clr = 1;
        @(posedge clk); #1; berr_clr = 0; pberr_clr = 0;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1; running = 1;
        @(negedge clk);
        chk("R1 bit_err", bit_err, 0);
        chk("R1 phy_err", phy_err, 0);
        chk("R1 txd", txd, 1);
        chk("R1 txd_oe", txd_oe, 0);
        chk("R1 err_irq", err_irq, 0);

        // standard detection
        send_byte(8'h55, 0, 0, 0);
        chk("R2 clean byte", bit_err, 0);
        send_byte(8'hA3, 1, 9, 3);
        chk("R2 glitch off sample 16", bit_err, 0);
        err_irq_en = 1;
        send_byte(8'hA3, 1, 16, 3);
        chk("R2 glitch at sample 16", bit_err, 1);
        chk("R8 irq with enable", err_irq, 1);
        clear_flags();
        chk("R4 cleared", bit_err, 0);

        // LIN mode off: fast and stop ignored
        fast_en = 1; stop_on_err = 1;
        send_byte(8'h0F, 1, 9, 2);
        chk("R12 fast ignored", bit_err, 0);
        send_byte(8'h0F, 1, 16, 2);
        chk("R12 stop ignored, flag", bit_err, 1);
        chk("R12 hold ignored", byte_hold, 0);
        clear_flags();
        stop_on_err = 0;

        // fast detection
        lin_mode = 1; fast_late = 0;
        send_byte(8'h3C, 1, 13, 4);
        chk("R3 early ignores 13", bit_err, 0);
        send_byte(8'h3C, 1, 9, 4);
        chk("R3 early at 9", bit_err, 1);
        clear_flags();
        fast_late = 1;
        send_byte(8'h3C, 1, 16, 5);
        chk("R3 late ignores 16", bit_err, 0);
        send_byte(8'h3C, 1, 13, 5);
        chk("R3 late at 13", bit_err, 1);
        clear_flags();

        // stop on error, hold of new bytes, DMA masking
        stop_on_err = 1; dma_stop_on_err = 1; dma_req_in = 1;
        send_byte(8'hC6, 1, 13, 2);
        chk("R5 released txd", txd, 1);
        chk("R5 released oe", txd_oe, 0);
        chk("R7 dma masked", dma_req, 0);
        send_byte(8'h00, 0, 0, 0);
        chk("R6 byte refused", txd_oe, 0);
        chk("R6 still held", byte_hold, 1);
        clear_flags();
        chk("R7 dma restored", dma_req, 1);
        send_byte(8'h81, 0, 0, 0);
        chk("R6 byte after clear", bit_err, 0);

        // set and clear in the same cycle (set wins, checked by model)
        berr_clr = 1;
        send_byte(8'h11, 1, 13, 1);
        berr_clr = 0;
        clear_flags();

        // physical bus error on the stop bit
        stop_on_err = 0;
        send_byte(8'hFF, 2, 0, 9);
        chk("R11 phy_err set", phy_err, 1);
        chk("R7 dma masked by phy", dma_req, 0);
        clear_flags();

        // inverted read-back and disabled output enable
        rx_invert = 1; tx_out_en = 0;
        send_byte(8'h5A, 0, 0, 0);
        chk("R9 inverted echo clean", bit_err, 0);
        chk("R10 oe low", txd_oe, 0);
        rx_invert = 0; tx_out_en = 1;

        running = 0; done = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule